// File: doc/BRIEF.md
# I2C Multi-Address Slave Matcher

This block judges a received I2C address byte for a slave port. It compares the upper seven bits of the byte with several own addresses. Each own address has its own mask, and a mask bit of 1 makes the matching address bit don't-care. When more than one address matches, the lowest-numbered slot wins.

Beyond plain matching, the block recognises the general-call byte. It also recognises two reserved bus-management headers: the device default address (`1100001x`) and the alert response header (`0001100x`). Enable bits decide whether the slave acknowledges or refuses each of these headers. The block also drives an active-low alert line.

All decisions are registered on a byte-valid strobe and hold until the next strobe. The serial shifter that assembles the byte and the logic that drives ACK onto SDA sit outside this block and use its results.

Top module: `i2c_multi_addr_match`

## Requirements
- R1: After synchronous reset, `hit`, `hit_idx`, `gen_call`, `rw` and `ack` are 0 and `alert_n` is 1.
- R2: Slot k matches when, for every bit i in 0..6, `rx_byte[i+1]` equals `own_addr[k*8+i+1]` or `own_mask[k*7+i]` is 1.
- R3: When several slots match, `hit_idx` reports the lowest-numbered one. `hit_idx` is 0 when nothing matches.
- R4: When `slave_mode` is 0, a strobe yields `hit`=0, `gen_call`=0 and `ack`=0.
- R5: `gen_call` is 1 only for the byte 0x00 with general call enabled, and general call is enabled by bit 0 of slot 0 (`own_addr[0]`). The byte 0x01 is not a general call.
- R6: When `manual_ack` is 1 and the byte is `1100001x`, `ack` equals `dflt_en`, even if an own address also matches.
- R7: When `manual_ack` and `dflt_en` are both 1 and the byte is `0001100x`, `ack` equals `alert_en`.
- R8: `alert_n` is the inverse of `alert_en` as sampled on the previous clock edge.
- R9: `hit`, `hit_idx`, `gen_call`, `rw` and `ack` change only on the edge that follows a cycle with `byte_vld` high. Otherwise they hold.
- R10: On each strobe, `rw` takes `rx_byte[0]`.
- R11: When neither reserved-header rule (R6, R7) applies, `ack` equals `hit` OR `gen_call`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Strobe: `rx_byte` holds a complete address byte |
| rx_byte | input | 8 | Received address byte, R/W in bit 0 |
| own_addr | input | 8*NUM_SLOTS | Own addresses in bits 7:1 of each byte; bit 0 of slot 0 enables general call |
| own_mask | input | 7*NUM_SLOTS | Per-slot don't-care masks |
| slave_mode | input | 1 | 1 = slave mode, comparison active |
| manual_ack | input | 1 | Software ACK control mode |
| dflt_en | input | 1 | Device default address enable |
| alert_en | input | 1 | Alert mode enable |
| hit | output | 1 | An own address matched |
| hit_idx | output | $clog2(NUM_SLOTS) | Index of the matching slot |
| gen_call | output | 1 | General call recognised |
| rw | output | 1 | Captured R/W bit |
| ack | output | 1 | ACK decision for the address byte |
| alert_n | output | 1 | Active-low alert output |

## Verification
The assertions check on every cycle that the results hold between strobes, that master mode suppresses every positive decision, that R/W is captured, that the alert line follows its enable, and that a non-zero byte never raises general call. In the absence of a manual-ACK override, they also check that `ack` agrees with the match results. Only the bench scenarios can show the masked comparison and the lowest-index priority among overlapping slots. They also show the reserved-header outcomes, including the case where the default header refuses a byte that an own slot would have matched.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] HDR_DEFAULT = 7'b1100001;
    localparam logic [ADDR_W-1:0] HDR_ALERT   = 7'b0001100;

    typedef enum logic [1:0] {
        HDR_NONE  = 2'd0,
        HDR_DFLT  = 2'd1,
        HDR_ALRT  = 2'd2,
        HDR_GCALL = 2'd3
    } hdr_kind_t;

    typedef struct packed {
        logic      is_dflt;
        logic      is_alert;
        logic      is_gcall;
    } hdr_flags_t;

    function automatic logic masked_eq(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b,
                                       input logic [ADDR_W-1:0] dc);
        return ((a ^ b) & ~dc) == '0;
    endfunction

endpackage

// File: rtl/addr_slot_cmp.sv
module addr_slot_cmp
    import i2c_addr_pkg::*;
(
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [ADDR_W-1:0] slot_mask,
    output logic              match
);
    always_comb match = masked_eq(rx_addr, slot_addr, slot_mask);
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/resv_hdr_dec.sv
module resv_hdr_dec
    import i2c_addr_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              gc_enable,
    output hdr_flags_t        flags
);
    always_comb begin
        flags.is_dflt  = (rx_byte[BYTE_W-1:1] == HDR_DEFAULT);
        flags.is_alert = (rx_byte[BYTE_W-1:1] == HDR_ALERT);
        flags.is_gcall = gc_enable && (rx_byte == '0);
    end
endmodule

// File: rtl/i2c_multi_addr_match.sv
module i2c_multi_addr_match
    import i2c_addr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        byte_vld,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  logic [NUM_SLOTS*BYTE_W-1:0] own_addr,
    input  logic [NUM_SLOTS*ADDR_W-1:0] own_mask,
    input  logic                        slave_mode,
    input  logic                        manual_ack,
    input  logic                        dflt_en,
    input  logic                        alert_en,
    output logic                        hit,
    output logic [IW-1:0]               hit_idx,
    output logic                        gen_call,
    output logic                        rw,
    output logic                        ack,
    output logic                        alert_n
);

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 any_hit;
    logic [IW-1:0]        pick_idx;
    hdr_flags_t           hdr;
    hdr_kind_t            kind;
    logic                 nx_ack;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        addr_slot_cmp u_cmp (
            .rx_addr   (rx_byte[BYTE_W-1:1]),
            .slot_addr (own_addr[k*BYTE_W+1 +: ADDR_W]),
            .slot_mask (own_mask[k*ADDR_W +: ADDR_W]),
            .match     (slot_hit[k])
        );
    end

    lowest_pick #(.N(NUM_SLOTS)) u_pick (
        .req (slot_hit),
        .any (any_hit),
        .idx (pick_idx)
    );

    resv_hdr_dec u_hdr (
        .rx_byte   (rx_byte),
        .gc_enable (own_addr[0]),
        .flags     (hdr)
    );

    // Select which rule governs the ACK decision.
    always_comb begin
        if (manual_ack && hdr.is_dflt)
            kind = HDR_DFLT;
        else if (manual_ack && dflt_en && hdr.is_alert)
            kind = HDR_ALRT;
        else if (hdr.is_gcall)
            kind = HDR_GCALL;
        else
            kind = HDR_NONE;
    end

    always_comb begin
        unique case (kind)
            HDR_DFLT:  nx_ack = dflt_en;
            HDR_ALRT:  nx_ack = alert_en;
            HDR_GCALL: nx_ack = 1'b1;
            default:   nx_ack = any_hit;
        endcase
        if (!slave_mode) nx_ack = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit      <= 1'b0;
            hit_idx  <= '0;
            gen_call <= 1'b0;
            rw       <= 1'b0;
            ack      <= 1'b0;
            alert_n  <= 1'b1;
        end else begin
            alert_n <= ~alert_en;
            if (byte_vld) begin
                hit      <= slave_mode && any_hit;
                hit_idx  <= (slave_mode && any_hit) ? pick_idx : '0;
                gen_call <= slave_mode && hdr.is_gcall;
                rw       <= rx_byte[0];
                ack      <= nx_ack;
            end
        end
    end

endmodule

// File: rtl/i2c_multi_addr_match_chk.sv
module i2c_multi_addr_match_chk #(
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          byte_vld,
    input logic [7:0]    rx_byte,
    input logic          slave_mode,
    input logic          manual_ack,
    input logic          alert_en,
    input logic          hit,
    input logic [IW-1:0] hit_idx,
    input logic          gen_call,
    input logic          rw,
    input logic          ack,
    input logic          alert_n
);

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> $stable({hit, hit_idx, gen_call, rw, ack})); // R9

    AST_MASTER_QUIET: assert property (@(posedge clk) disable iff (rst)
        byte_vld && !slave_mode |=> !hit && !gen_call && !ack); // R4

    AST_RW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> rw == $past(rx_byte[0])); // R10

    AST_ALERT_LINE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> alert_n == !$past(alert_en)); // R8

    AST_GCALL_ZERO_ONLY: assert property (@(posedge clk) disable iff (rst)
        byte_vld && rx_byte != 8'h00 |=> !gen_call); // R5

    AST_IDX_IDLE: assert property (@(posedge clk) disable iff (rst)
        !hit |-> hit_idx == '0); // R3

    AST_ACK_PLAIN: assert property (@(posedge clk) disable iff (rst)
        byte_vld && !manual_ack |=> ack == (hit || gen_call)); // R11

endmodule

bind i2c_multi_addr_match i2c_multi_addr_match_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_vld   (byte_vld),
    .rx_byte    (rx_byte),
    .slave_mode (slave_mode),
    .manual_ack (manual_ack),
    .alert_en   (alert_en),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .gen_call   (gen_call),
    .rw         (rw),
    .ack        (ack),
    .alert_n    (alert_n)
);

// File: tb/i2c_multi_addr_match_test.sv
module i2c_multi_addr_match_test;

    localparam int NS = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          byte_vld = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic [NS*8-1:0] own_addr = '0;
    logic [NS*7-1:0] own_mask = '0;
    logic          slave_mode = 1'b1;
    logic          manual_ack = 1'b0;
    logic          dflt_en = 1'b0;
    logic          alert_en = 1'b0;
    logic          hit, gen_call, rw, ack, alert_n;
    logic [IW-1:0] hit_idx;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    i2c_multi_addr_match #(.NUM_SLOTS(NS)) uut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .rx_byte(rx_byte),
        .own_addr(own_addr), .own_mask(own_mask), .slave_mode(slave_mode),
        .manual_ack(manual_ack), .dflt_en(dflt_en), .alert_en(alert_en),
        .hit(hit), .hit_idx(hit_idx), .gen_call(gen_call), .rw(rw),
        .ack(ack), .alert_n(alert_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_slot(input int k, input logic [6:0] a, input logic [6:0] m);
        own_addr[k*8+1 +: 7] = a;
        own_mask[k*7 +: 7]   = m;
    endtask

    // Present one byte for one cycle; results are visible at the next negedge.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 hit", hit, 0);
        chk("R1 idx", hit_idx, 0);
        chk("R1 gen_call", gen_call, 0);
        chk("R1 rw", rw, 0);
        chk("R1 ack", ack, 0);
        chk("R1 alert_n", alert_n, 1);
    endtask

    task automatic t_masked;
        send({7'h2F, 1'b0});   // slot1 0x20 mask 0x0F
        chk("R2 masked hit", hit, 1);
        chk("R2 masked idx", hit_idx, 1);
        chk("R11 ack on hit", ack, 1);
        send({7'h30, 1'b0});   // outside mask range, no slot
        chk("R2 miss", hit, 0);
        chk("R3 idx on miss", hit_idx, 0);
        chk("R11 nack on miss", ack, 0);
        send({7'h33, 1'b1});   // slot3 exact
        chk("R2 exact slot3", hit_idx, 3);
        chk("R10 rw one", rw, 1);
    endtask

    task automatic t_priority;
        send({7'h2A, 1'b0});   // slots 1 and 2 both match
        chk("R3 overlap hit", hit, 1);
        chk("R3 lowest idx", hit_idx, 1);
        chk("R10 rw zero", rw, 0);
        send({7'h50, 1'b0});   // slot0 only
        chk("R3 slot0 idx", hit_idx, 0);
        chk("R3 slot0 hit", hit, 1);
    endtask

    task automatic t_master;
        slave_mode = 1'b0;
        send({7'h50, 1'b0});
        chk("R4 master hit", hit, 0);
        chk("R4 master ack", ack, 0);
        send(8'h00);
        chk("R4 master gcall", gen_call, 0);
        slave_mode = 1'b1;
    endtask

    task automatic t_gcall;
        send(8'h00);
        chk("R5 gcall on", gen_call, 1);
        chk("R11 gcall ack", ack, 1);
        send(8'h01);
        chk("R5 gcall read", gen_call, 0);
        own_addr[0] = 1'b0;
        send(8'h00);
        chk("R5 gcall disabled", gen_call, 0);
        chk("R5 gcall disabled ack", ack, 0);
        own_addr[0] = 1'b1;
    endtask

    task automatic t_default;
        manual_ack = 1'b1;
        dflt_en    = 1'b1;
        send(8'hC2);
        chk("R6 default acked", ack, 1);
        dflt_en = 1'b0;
        send(8'hC3);
        chk("R6 default refused", ack, 0);
        set_slot(3, 7'h61, 7'h00);   // own match on the default header
        send(8'hC2);
        chk("R6 override own hit", hit, 1);
        chk("R6 override own ack", ack, 0);
        set_slot(3, 7'h33, 7'h00);
        manual_ack = 1'b0;
    endtask

    task automatic t_alert;
        manual_ack = 1'b1;
        dflt_en    = 1'b1;
        alert_en   = 1'b1;
        send(8'h18);
        chk("R7 alert acked", ack, 1);
        chk("R8 alert_n low", alert_n, 0);
        alert_en = 1'b0;
        send(8'h19);
        chk("R7 alert refused", ack, 0);
        chk("R8 alert_n high", alert_n, 1);
        manual_ack = 1'b0;
        dflt_en    = 1'b0;
        alert_en   = 1'b1;
        send(8'h18);
        chk("R11 alert plain nack", ack, 0);
        alert_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hold;
        send({7'h2B, 1'b1});
        chk("R9 setup idx", hit_idx, 1);
        @(negedge clk);
        rx_byte = 8'h00;
        repeat (3) @(negedge clk);
        chk("R9 hold hit", hit, 1);
        chk("R9 hold idx", hit_idx, 1);
        chk("R9 hold gcall", gen_call, 0);
        chk("R9 hold rw", rw, 1);
        chk("R9 hold ack", ack, 1);
    endtask

    initial begin
        set_slot(0, 7'h50, 7'h00);
        own_addr[0] = 1'b1;
        set_slot(1, 7'h20, 7'h0F);
        set_slot(2, 7'h2A, 7'h00);
        set_slot(3, 7'h33, 7'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_masked();
        t_priority();
        t_master();
        t_gcall();
        t_default();
        t_alert();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule